// File: doc/BRIEF.md
# Logarithmic-Domain Adder/Subtractor with Table Correction

This block adds or subtracts two numbers held in logarithmic form. Each operand is a sign bit plus a two's-complement fixed-point base-2 logarithm of its magnitude. With the default parameters this logarithm has 5 integer bits and 8 fractional bits. The most negative logarithm code, a one followed by zeros, stands for the value zero.

The block first puts the two operands in order so that the larger magnitude, x, comes first. It then takes the non-negative gap between the two logarithms. It reads a correction term from one of two internal tables, one for a sum of magnitudes and one for a difference of magnitudes. It adds that term to the logarithm of x. Both tables are computed when the design is elaborated.

A four-way output selector chooses the final result. It can pass either operand through unchanged, give the exact zero code, or give the computed value. It passes an operand when the other one is zero or when the gap is too large for the table. It gives zero when both operands are zero or when equal magnitudes cancel.

Results are registered and appear one clock after a valid request. The table is indexed at coarse steps of the gap, and there is no interpolation. The block therefore suits uses where roughly eight fractional bits are enough.

Top module: `lns_addsub`

## Requirements
- R1: While reset is high, and after it, until the first valid request, `out_valid` is 0, `out_sign` is 0 and `out_log` holds the zero code (0x1000 at default width).
- R2: `out_valid` equals `in_valid` from one clock earlier. When `in_valid` is low, `out_sign` and `out_log` keep their previous values.
- R3: Operand b takes part with sign `b_sign ^ sub`, where `sub`=1 requests a-b. The larger logarithm (signed compare; a on a tie) is x. A non-zero computed result carries the sign of x.
- R4: When the signs taken for a and b are equal, the sum table is used, phi(t)=log2(1+2^-t). Otherwise the difference table is used, phi(t)=log2(1-2^-t). With gap g = Lx-Ly in LSBs, t=(floor(g/8)+0.5)/32, and the result logarithm is Lx + round(256*phi(t)).
- R5: When g is 4096 LSBs (a logarithm gap of 16.0) or more, the result is x exactly, with its sign and logarithm unchanged.
- R6: If only b is zero, the result is a as given. If only a is zero, the result is b with sign `b_sign ^ sub`. The zero test looks at the logarithm field alone.
- R7: Every zero result is the zero code with sign 0. This includes the result when both operands are zero.
- R8: When the two signs taken differ and the logarithms are equal, the result is zero.
- R9: A computed logarithm above the largest code (0x0FFF) saturates to 0x0FFF.
- R10: A computed logarithm at or below the zero code gives the zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; operands sampled on this cycle |
| sub | input | 1 | 0: a+b, 1: a-b |
| a_sign | input | 1 | Sign of operand a (1 = negative) |
| a_log | input | LW | Logarithm of operand a, two's complement, FRAC_W fraction bits |
| b_sign | input | 1 | Sign of operand b |
| b_log | input | LW | Logarithm of operand b |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_sign | output | 1 | Sign of result |
| out_log | output | LW | Logarithm of result |

## Verification
The bound checker watches several things on every cycle. It checks the one-cycle valid timing and that the result holds between requests. It checks that a zero result always carries sign 0, that a zero b passes a through, that equal magnitudes cancel, and that the larger operand gives the result its sign. Only the bench scenarios can show the rest. That covers the table values in both the sum and difference regions, including the steep part just below a gap of zero. It also covers the exact bypass threshold at a gap of 16.0 and both saturation and underflow at the ends of the range. For these, the bench compares every cycle against a real-valued model built from the requirement formulas.

// File: rtl/lns_pkg.sv
package lns_pkg;

  typedef enum logic [1:0] {
    SEL_SUM  = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2,
    SEL_ZERO = 2'd3
  } sel_e;

  // Correction term in result LSBs for table cell idx, evaluated at the
  // cell midpoint so the difference table never reaches log2(0).
  function automatic int phi_code(int idx, bit diff_tab, int tab_frac, int frac_w);
    real mid;
    real t;
    real v;
    mid = (real'(idx) + 0.5) / real'(1 << tab_frac);
    t   = $exp(-mid * $ln(2.0));
    if (diff_tab) v = $ln(1.0 - t) / $ln(2.0);
    else          v = $ln(1.0 + t) / $ln(2.0);
    return $rtoi($floor(v * real'(1 << frac_w) + 0.5));
  endfunction

endpackage

// File: rtl/lns_order.sv
module lns_order #(
  parameter int LW       = 13,
  parameter int FRAC_W   = 8,
  parameter int TAB_INT  = 4,
  parameter int TAB_FRAC = 5
) (
  input  logic              a_sign,
  input  logic [LW-1:0]     a_log,
  input  logic              b_sign,
  input  logic [LW-1:0]     b_log,
  input  logic              sub,
  output logic              q_sign,
  output logic              a_zero,
  output logic              b_zero,
  output logic              same_log,
  output logic              a_ge,
  output logic              eff_sub,
  output logic              x_sign,
  output logic [LW-1:0]     x_log,
  output logic [TAB_INT+TAB_FRAC-1:0] idx,
  output logic              bypass
);
  localparam int SHIFT = FRAC_W - TAB_FRAC;
  localparam int IDX_W = TAB_INT + TAB_FRAC;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [LW-1:0] ZERO_CODE = {1'b1, {(LW-1){1'b0}}};

  logic [LW-1:0] y_log;
  logic [LW:0]   gap;
  logic [LW:0]   gap_sh;

  always_comb begin
    q_sign   = b_sign ^ sub;
    a_zero   = (a_log == ZERO_CODE);
    b_zero   = (b_log == ZERO_CODE);
    same_log = (a_log == b_log);
    a_ge     = ($signed(a_log) >= $signed(b_log));
    eff_sub  = a_sign ^ q_sign;
    x_sign   = a_ge ? a_sign : q_sign;
    x_log    = a_ge ? a_log  : b_log;
    y_log    = a_ge ? b_log  : a_log;
    gap      = {x_log[LW-1], x_log} - {y_log[LW-1], y_log};
    gap_sh   = gap >> SHIFT;
    bypass   = (gap_sh >= (LW+1)'(DEPTH));
    idx      = gap_sh[IDX_W-1:0];
  end
endmodule

// File: rtl/lns_phi_rom.sv
module lns_phi_rom #(
  parameter int FRAC_W   = 8,
  parameter int TAB_INT  = 4,
  parameter int TAB_FRAC = 5,
  parameter int PHI_W    = 12
) (
  input  logic [TAB_INT+TAB_FRAC-1:0] idx,
  input  logic                        diff_sel,
  output logic signed [PHI_W-1:0]     phi
);
  import lns_pkg::*;

  localparam int IDX_W = TAB_INT + TAB_FRAC;
  localparam int DEPTH = 1 << IDX_W;

  logic signed [PHI_W-1:0] tab_out [2];

  for (genvar t = 0; t < 2; t++) begin : g_tab
    logic signed [PHI_W-1:0] rom [DEPTH];
    initial begin
      for (int i = 0; i < DEPTH; i++)
        rom[i] = PHI_W'(phi_code(i, (t == 1), TAB_FRAC, FRAC_W));
    end
    assign tab_out[t] = rom[idx];
  end

  assign phi = diff_sel ? tab_out[1] : tab_out[0];
endmodule

// File: rtl/lns_out_sel.sv
module lns_out_sel #(
  parameter int LW    = 13,
  parameter int PHI_W = 12
) (
  input  logic                    a_sign,
  input  logic [LW-1:0]           a_log,
  input  logic                    q_sign,
  input  logic [LW-1:0]           b_log,
  input  logic                    a_zero,
  input  logic                    b_zero,
  input  logic                    same_log,
  input  logic                    eff_sub,
  input  logic                    bypass,
  input  logic                    a_ge,
  input  logic                    x_sign,
  input  logic [LW-1:0]           x_log,
  input  logic signed [PHI_W-1:0] phi,
  output logic                    r_sign,
  output logic [LW-1:0]           r_log
);
  import lns_pkg::*;

  localparam int SUM_W = ((LW > PHI_W) ? LW : PHI_W) + 1;
  localparam int MAX_I = (1 << (LW-1)) - 1;
  localparam int MIN_I = -(1 << (LW-1));
  localparam logic [LW-1:0] ZERO_CODE = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] MAX_CODE  = {1'b0, {(LW-1){1'b1}}};

  logic signed [SUM_W-1:0] sum;
  logic [LW-1:0]           sum_log;
  logic                    sum_low;
  sel_e                    sel;

  always_comb begin
    sum     = SUM_W'($signed(x_log)) + SUM_W'(phi);
    sum_low = (sum <= $signed(SUM_W'(MIN_I)));
    if (sum > $signed(SUM_W'(MAX_I))) sum_log = MAX_CODE;
    else                              sum_log = sum[LW-1:0];
  end

  always_comb begin
    if (a_zero && b_zero)          sel = SEL_ZERO;
    else if (b_zero)               sel = SEL_A;
    else if (a_zero)               sel = SEL_B;
    else if (eff_sub && same_log)  sel = SEL_ZERO;
    else if (bypass)               sel = a_ge ? SEL_A : SEL_B;
    else if (sum_low)              sel = SEL_ZERO;
    else                           sel = SEL_SUM;
  end

  always_comb begin
    unique case (sel)
      SEL_A:    begin r_sign = a_sign; r_log = a_log;     end
      SEL_B:    begin r_sign = q_sign; r_log = b_log;     end
      SEL_ZERO: begin r_sign = 1'b0;   r_log = ZERO_CODE; end
      default:  begin r_sign = x_sign; r_log = sum_log;   end
    endcase
  end
endmodule

// File: rtl/lns_addsub.sv
module lns_addsub #(
  parameter int INT_W    = 5,
  parameter int FRAC_W   = 8,
  parameter int TAB_INT  = 4,
  parameter int TAB_FRAC = 5,
  localparam int LW      = INT_W + FRAC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          sub,
  input  logic          a_sign,
  input  logic [LW-1:0] a_log,
  input  logic          b_sign,
  input  logic [LW-1:0] b_log,
  output logic          out_valid,
  output logic          out_sign,
  output logic [LW-1:0] out_log
);
  localparam int IDX_W = TAB_INT + TAB_FRAC;
  // difference table bottoms out near -(TAB_FRAC+1.6); one spare bit plus sign
  localparam int PHI_W = FRAC_W + $clog2(TAB_FRAC + 2) + 1;
  localparam logic [LW-1:0] ZERO_CODE = {1'b1, {(LW-1){1'b0}}};

  logic             q_sign, a_zero, b_zero, same_log, a_ge, eff_sub, x_sign, bypass;
  logic [LW-1:0]    x_log;
  logic [IDX_W-1:0] idx;
  logic signed [PHI_W-1:0] phi;
  logic             r_sign;
  logic [LW-1:0]    r_log;

  lns_order #(
    .LW(LW), .FRAC_W(FRAC_W), .TAB_INT(TAB_INT), .TAB_FRAC(TAB_FRAC)
  ) order_i (
    .a_sign(a_sign), .a_log(a_log), .b_sign(b_sign), .b_log(b_log), .sub(sub),
    .q_sign(q_sign), .a_zero(a_zero), .b_zero(b_zero), .same_log(same_log),
    .a_ge(a_ge), .eff_sub(eff_sub), .x_sign(x_sign), .x_log(x_log),
    .idx(idx), .bypass(bypass)
  );

  lns_phi_rom #(
    .FRAC_W(FRAC_W), .TAB_INT(TAB_INT), .TAB_FRAC(TAB_FRAC), .PHI_W(PHI_W)
  ) rom_i (
    .idx(idx), .diff_sel(eff_sub), .phi(phi)
  );

  lns_out_sel #(
    .LW(LW), .PHI_W(PHI_W)
  ) sel_i (
    .a_sign(a_sign), .a_log(a_log), .q_sign(q_sign), .b_log(b_log),
    .a_zero(a_zero), .b_zero(b_zero), .same_log(same_log), .eff_sub(eff_sub),
    .bypass(bypass), .a_ge(a_ge), .x_sign(x_sign), .x_log(x_log), .phi(phi),
    .r_sign(r_sign), .r_log(r_log)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_log   <= ZERO_CODE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= r_sign;
        out_log  <= r_log;
      end
    end
  end
endmodule

// File: rtl/lns_addsub_chk.sv
module lns_addsub_chk #(
  parameter int LW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          sub,
  input logic          a_sign,
  input logic [LW-1:0] a_log,
  input logic          b_sign,
  input logic [LW-1:0] b_log,
  input logic          out_valid,
  input logic          out_sign,
  input logic [LW-1:0] out_log
);
  localparam logic [LW-1:0] ZERO_CODE = {1'b1, {(LW-1){1'b0}}};

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(out_log) && $stable(out_sign))); // R2

  AST_ZERO_CANON: assert property (@(posedge clk) disable iff (rst)
    (out_log == ZERO_CODE) |-> !out_sign); // R7

  AST_B_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && b_log == ZERO_CODE && a_log != ZERO_CODE))
      |-> (out_log == $past(a_log) && out_sign == $past(a_sign))); // R6

  AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && a_log == b_log && (a_sign ^ b_sign ^ sub)))
      |-> (out_log == ZERO_CODE)); // R8

  AST_LARGER_SIGN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && b_log != ZERO_CODE && $signed(a_log) > $signed(b_log))
      && out_log != ZERO_CODE) |-> (out_sign == $past(a_sign))); // R3

endmodule

bind lns_addsub lns_addsub_chk #(.LW(LW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sub(sub),
  .a_sign(a_sign), .a_log(a_log), .b_sign(b_sign), .b_log(b_log),
  .out_valid(out_valid), .out_sign(out_sign), .out_log(out_log)
);

// File: tb/lns_addsub_tb.sv
module lns_addsub_tb_top;
  localparam int LW    = 13;
  localparam int MIN_I = -4096;
  localparam int MAX_I = 4095;
  localparam logic [LW-1:0] ZC = 13'h1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          sub = 1'b0;
  logic          a_sign = 1'b0;
  logic [LW-1:0] a_log = '0;
  logic          b_sign = 1'b0;
  logic [LW-1:0] b_log = '0;
  logic          out_valid;
  logic          out_sign;
  logic [LW-1:0] out_log;

  int n_tests = 0;
  int n_fail  = 0;

  logic          m_valid;
  logic          m_sign;
  logic [LW-1:0] m_log;

  always #10 clk = ~clk;

  lns_addsub dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sub(sub),
    .a_sign(a_sign), .a_log(a_log), .b_sign(b_sign), .b_log(b_log),
    .out_valid(out_valid), .out_sign(out_sign), .out_log(out_log)
  );

  function automatic logic [LW-1:0] enc(real v);
    return LW'($rtoi($floor(v * 256.0 + 0.5)));
  endfunction

  // Behavioural model written from the requirement formulas.
  function automatic logic [LW:0] model(logic as, logic [LW-1:0] la,
                                        logic bs, logic [LW-1:0] lb, logic sb);
    int  ia, ib, xl, g, code, s;
    logic qs, xs;
    real t, phi;
    qs = bs ^ sb;
    ia = int'($signed(la));
    ib = int'($signed(lb));
    if (la == ZC && lb == ZC) return {1'b0, ZC};
    if (lb == ZC) return {as, la};
    if (la == ZC) return {qs, lb};
    if (ia == ib && as != qs) return {1'b0, ZC};
    if (ia >= ib) begin xs = as; xl = ia; g = ia - ib; end
    else          begin xs = qs; xl = ib; g = ib - ia; end
    if (g >= 4096) return {xs, LW'(xl)};
    t = ($floor(real'(g) / 8.0) + 0.5) / 32.0;
    if (as == qs) phi = $ln(1.0 + $exp(-t * $ln(2.0))) / $ln(2.0);
    else          phi = $ln(1.0 - $exp(-t * $ln(2.0))) / $ln(2.0);
    code = $rtoi($floor(phi * 256.0 + 0.5));
    s = xl + code;
    if (s > MAX_I)  return {xs, LW'(MAX_I)};
    if (s <= MIN_I) return {1'b0, ZC};
    return {xs, LW'(s)};
  endfunction

  task automatic compare(string tag);
    n_tests++;
    if (out_valid !== m_valid || out_sign !== m_sign || out_log !== m_log) begin
      n_fail++;
      $display("FAIL %s: got v=%0b s=%0b l=%h exp v=%0b s=%0b l=%h",
               tag, out_valid, out_sign, out_log, m_valid, m_sign, m_log);
    end
  endtask

  // Called at a negedge: drive, advance model at the edge, compare at next negedge.
  task automatic step(logic v, logic sb, logic as, logic [LW-1:0] la,
                      logic bs, logic [LW-1:0] lb, string tag);
    logic [LW:0] r;
    in_valid = v; sub = sb; a_sign = as; a_log = la; b_sign = bs; b_log = lb;
    @(posedge clk);
    m_valid = v;
    if (v) begin
      r = model(as, la, bs, lb, sb);
      m_sign = r[LW];
      m_log  = r[LW-1:0];
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    m_valid = 1'b0; m_sign = 1'b0; m_log = ZC;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b1, enc(2.0), 1'b1, enc(1.0), "R1 idle after reset");

    step(1'b1, 1'b0, 1'b0, enc(3.0),  1'b0, enc(1.0), "R4 sum gap 2");
    step(1'b1, 1'b1, 1'b0, enc(3.0),  1'b0, enc(1.0), "R4 diff gap 2");
    step(1'b1, 1'b0, 1'b0, enc(-2.5), 1'b0, enc(-2.5), "R4 equal sum");
    step(1'b1, 1'b1, 1'b0, enc(1.0),  1'b0, LW'(enc(1.0) - 1), "R4 diff gap 1 LSB");
    step(1'b1, 1'b1, 1'b0, enc(0.5),  1'b0, enc(0.25), "R4 diff gap 0.25");
    step(1'b1, 1'b0, 1'b0, enc(1.0),  1'b1, enc(2.5), "R3 b larger eff diff");
    step(1'b1, 1'b1, 1'b0, enc(-1.0), 1'b1, enc(4.0), "R3 sub neg b eff sum");
    step(1'b1, 1'b1, 1'b1, enc(6.0),  1'b0, enc(-3.0), "R3 a larger neg");
    step(1'b0, 1'b0, 1'b0, enc(9.0),  1'b0, enc(9.0), "R2 hold on idle");
    step(1'b0, 1'b1, 1'b1, enc(-7.0), 1'b0, ZC,       "R2 hold second idle");
    step(1'b1, 1'b0, 1'b1, enc(10.0), 1'b0, enc(-7.0), "R5 gap 17 bypass");
    step(1'b1, 1'b1, 1'b0, enc(8.0),  1'b0, enc(-8.0), "R5 gap exactly 16");
    step(1'b1, 1'b1, 1'b0, enc(-8.0), 1'b1, enc(8.0),  "R5 gap 16 b larger");
    step(1'b1, 1'b0, 1'b0, enc(8.0),  1'b0, LW'(enc(-8.0) + 1), "R5 gap just under 16");
    step(1'b1, 1'b0, 1'b1, enc(2.0),  1'b0, ZC,        "R6 b zero passes a");
    step(1'b1, 1'b1, 1'b0, ZC,        1'b0, enc(5.0),  "R6 a zero passes -b");
    step(1'b1, 1'b1, 1'b1, ZC,        1'b1, ZC,        "R7 both zero");
    step(1'b1, 1'b1, 1'b0, enc(4.0),  1'b0, enc(4.0),  "R8 cancel by sub");
    step(1'b1, 1'b0, 1'b1, enc(4.0),  1'b0, enc(4.0),  "R8 cancel by signs");
    step(1'b1, 1'b0, 1'b0, LW'(MAX_I), 1'b0, LW'(MAX_I), "R9 saturate max");
    step(1'b1, 1'b0, 1'b1, enc(15.5), 1'b1, enc(15.0), "R9 saturate near top");
    step(1'b1, 1'b1, 1'b0, enc(-12.0), 1'b0, LW'(enc(-12.0) - 1), "R10 underflow");

    for (int k = 0; k < 300; k++) begin
      logic [LW-1:0] la, lb;
      int d;
      la = LW'($urandom_range(0, 8191));
      if (k % 3 == 0) begin
        d  = int'($urandom_range(0, 600)) - 300;
        lb = LW'(int'($signed(la)) + d);
      end else begin
        lb = LW'($urandom_range(0, 8191));
      end
      if (k % 17 == 0) la = ZC;
      if (k % 23 == 0) lb = ZC;
      step(1'(k % 5 != 4), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), la,
           1'($urandom_range(0, 1)), lb, "R4 mixed pattern");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got running exp finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule